// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block is the software-facing half of a synchronous serial port. It decodes a 4 KB window on a simple single-cycle read/write bus. It holds the configuration registers and owns two 8-entry FIFOs: one holds words waiting to be sent and the other holds words that have been received. One data register serves both FIFOs. A bus write to it queues a transmit word, and a bus read from it takes the oldest received word. A separate transfer engine, which is not part of this block, removes transmit words through a pop strobe and delivers received words through a push strobe.

Status flags and interrupts come straight from the two FIFO fill levels, so no event latching is needed. The block gives out the raw interrupt vector, the vector after the enable mask, and a single combined interrupt line. The top eight words of the window return fixed identification bytes. Reads from offsets that are not defined return zero. Such accesses also raise a one-cycle error pulse, which makes them easy to observe.

Bus reads are combinational: `rdata` shows the addressed register whenever `sel` is high and `wr` is low. Writes and pops take effect on the rising clock edge. The address is decoded into an enumerated register selector (control 0, control 1, data, status, prescale, mask, raw, masked, DMA control, identification, none) by a single `unique case`. Every access is complete in one cycle, so the block keeps no access state between cycles.

Top module: `ssp_regfront`

## Requirements
- R1: After reset both FIFOs are empty, the mask is 0 and `irq` is low. The status word (offset 0x0C) reads 0x03. The raw interrupt word (0x18) reads 0x08.
- R2: Control 0 (0x00) stores all 16 bits. Control 1 (0x04) keeps bits 3:0. Prescale (0x10) keeps bits 7:0. Mask (0x14) keeps bits 3:0. DMA control (0x20) always reads 0. Each register is readable at its offset.
- R3: A read of word-aligned offsets 0xFE0 to 0xFFC returns, in address order, 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: A write to data (0x08) queues the value masked to the frame width, which is control 0 bits 3:0 plus one. `tx_valid`/`tx_data` present the oldest queued word in first-in first-out order, and `tx_pop` removes it.
- R5: A data write while the transmit FIFO holds 8 words is discarded.
- R6: A data read returns the oldest received word and removes it. With the receive FIFO empty, the read returns 0 and changes nothing.
- R7: `rx_ready` is low while the receive FIFO holds 8 words, and `rx_push` is then ignored. A pushed word is masked to the frame width.
- R8: Status bits: bit 0 is transmit FIFO empty, bit 1 is transmit not full, bit 2 is receive not empty, bit 3 is receive full, and bit 4 is busy (the transmit FIFO holds at least one word).
- R9: Raw interrupt bit 2 is set while the receive FIFO holds at least 4 words. Raw bit 3 is set while the transmit FIFO holds at most 4 words. Raw bits 1:0 are 0.
- R10: `irq_masked` and the masked word (0x1C) equal raw AND mask. `irq` is high exactly when that AND is nonzero.
- R11: An access to an undefined or unaligned offset reads 0 and writes nothing. `bus_err` is high for the single cycle after each such access.
- R12: A push and a pop on the same FIFO in the same cycle leave its fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus access this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| bus_err | output | 1 | Pulse after an undefined access |
| irq | output | 1 | Combined interrupt |
| irq_raw | output | 4 | Raw interrupt vector |
| irq_masked | output | 4 | Raw AND mask |
| ctrl0 | output | 16 | Control 0 to the transfer engine |
| ctrl1 | output | 4 | Control 1 to the transfer engine |
| prescale | output | 8 | Clock prescale to the transfer engine |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_data | output | 16 | Oldest transmit word |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_data | input | 16 | Received word |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
Assertions check several properties on every cycle. The FIFO fill levels never go past 8, a push into a full FIFO or a pop from an empty FIFO leaves its level unchanged, and a simultaneous push and pop keep the level constant. The busy flag always agrees with `tx_valid`, and the combined interrupt never rises while the mask is zero. Every error pulse follows an undefined access. Only the bench scenarios can show the data itself: that words come out in order and masked to the frame width, the identification bytes, the register field widths, and that the interrupt thresholds switch exactly at 4 entries. The behavioural reference model covers these.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL0,
        SEL_CTRL1,
        SEL_DATA,
        SEL_STAT,
        SEL_PRESC,
        SEL_MASK,
        SEL_RAW,
        SEL_MSK,
        SEL_DMA,
        SEL_IDENT
    } reg_sel_e;

    localparam int WORD_W     = 10;
    localparam logic [WORD_W-1:0] IDENT_BASE = 10'h3F8;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h22;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wptr_q] <= push_data;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R5
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt_q == CNT_W'(DEPTH))); // R5
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (cnt_q == '0)); // R6
    AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/ssp_status.sv
module ssp_status #(
    parameter int DEPTH  = 8,
    parameter int RX_LVL = DEPTH / 2,
    parameter int TX_LVL = DEPTH / 2,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [3:0]       mask,
    output logic [4:0]       stat,
    output logic [3:0]       raw,
    output logic [3:0]       masked,
    output logic             irq
);
    always_comb begin
        stat[0] = (tx_count == '0);
        stat[1] = (tx_count != CNT_W'(DEPTH));
        stat[2] = (rx_count != '0);
        stat[3] = (rx_count == CNT_W'(DEPTH));
        stat[4] = (tx_count != '0);
        raw     = '0;
        raw[2]  = (rx_count >= CNT_W'(RX_LVL));
        raw[3]  = (tx_count <= CNT_W'(TX_LVL));
        masked  = raw & mask;
        irq     = |masked;
    end
endmodule

// File: rtl/ssp_regfront.sv
module ssp_regfront
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int FLD_W = $clog2(DATA_W),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [11:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_err,
    output logic              irq,
    output logic [3:0]        irq_raw,
    output logic [3:0]        irq_masked,
    output logic [DATA_W-1:0] ctrl0,
    output logic [3:0]        ctrl1,
    output logic [7:0]        prescale,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready
);
    reg_sel_e           sel_e;
    logic [WORD_W-1:0]  word;
    logic [DATA_W-1:0]  ctrl0_q;
    logic [3:0]         ctrl1_q, mask_q;
    logic [7:0]         presc_q;
    logic               err_q;
    logic [DATA_W:0]    mask_wide;
    logic [DATA_W-1:0]  frame_mask;
    logic               tx_push, rx_pop;
    logic               tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0]  rx_head;
    logic [CNT_W-1:0]   tx_count, rx_count;
    logic [4:0]         stat;

    assign word = addr[11:2];

    // address decode
    always_comb begin
        sel_e = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (word)
                10'd0:   sel_e = SEL_CTRL0;
                10'd1:   sel_e = SEL_CTRL1;
                10'd2:   sel_e = SEL_DATA;
                10'd3:   sel_e = SEL_STAT;
                10'd4:   sel_e = SEL_PRESC;
                10'd5:   sel_e = SEL_MASK;
                10'd6:   sel_e = SEL_RAW;
                10'd7:   sel_e = SEL_MSK;
                10'd8:   sel_e = SEL_DMA;
                default: sel_e = (word >= IDENT_BASE) ? SEL_IDENT : SEL_NONE;
            endcase
        end
    end

    always_comb begin
        mask_wide  = ((DATA_W+1)'(1) << (int'(ctrl0_q[FLD_W-1:0]) + 1)) - (DATA_W+1)'(1);
        frame_mask = mask_wide[DATA_W-1:0];
    end

    assign tx_push = sel && wr && (sel_e == SEL_DATA);
    assign rx_pop  = sel && !wr && (sel_e == SEL_DATA);

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            presc_q <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= sel && (sel_e == SEL_NONE);
            if (sel && wr) begin
                unique case (sel_e)
                    SEL_CTRL0: ctrl0_q <= wdata;
                    SEL_CTRL1: ctrl1_q <= wdata[3:0];
                    SEL_PRESC: presc_q <= wdata[7:0];
                    SEL_MASK:  mask_q  <= wdata[3:0];
                    default:   ;
                endcase
            end
        end
    end

    ssp_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(wdata & frame_mask),
        .pop(tx_pop), .head(tx_data),
        .empty(tx_empty), .full(tx_full), .count(tx_count)
    );

    ssp_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_data & frame_mask),
        .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    ssp_status #(.DEPTH(DEPTH)) u_status (
        .tx_count(tx_count), .rx_count(rx_count), .mask(mask_q),
        .stat(stat), .raw(irq_raw), .masked(irq_masked), .irq(irq)
    );

    // read mux
    always_comb begin
        rdata = '0;
        unique case (sel_e)
            SEL_CTRL0: rdata = ctrl0_q;
            SEL_CTRL1: rdata = DATA_W'(ctrl1_q);
            SEL_DATA:  rdata = rx_empty ? '0 : rx_head;
            SEL_STAT:  rdata = DATA_W'(stat);
            SEL_PRESC: rdata = DATA_W'(presc_q);
            SEL_MASK:  rdata = DATA_W'(mask_q);
            SEL_RAW:   rdata = DATA_W'(irq_raw);
            SEL_MSK:   rdata = DATA_W'(irq_masked);
            SEL_IDENT: rdata = DATA_W'(ident_byte(word[2:0]));
            default:   rdata = '0;
        endcase
    end

    assign bus_err  = err_q;
    assign ctrl0    = ctrl0_q;
    assign ctrl1    = ctrl1_q;
    assign prescale = presc_q;
    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    AST_BUSY_TRACKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        stat[4] == tx_valid); // R8
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != 4'h0)); // R10
    AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(sel && (sel_e == SEL_NONE))); // R11
    AST_DROP_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop) |=> (tx_count == CNT_W'(DEPTH))); // R5

endmodule

// File: tb/test_ssp_regfront.sv
module test_ssp_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        bus_err, irq, tx_valid, rx_ready;
    logic [3:0]  irq_raw, irq_masked, ctrl1;
    logic [15:0] ctrl0, tx_data;
    logic [7:0]  prescale;
    logic        tx_pop = 1'b0, rx_push = 1'b0;
    logic [15:0] rx_data = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ssp_regfront i_ssp_regfront (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bus_err(bus_err), .irq(irq),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .ctrl0(ctrl0),
        .ctrl1(ctrl1), .prescale(prescale), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_data), .rx_ready(rx_ready)
    );

    // behavioural reference model
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    logic [15:0] m_ctrl0;
    logic [3:0]  m_mask;
    bit          m_err;

    function automatic logic [15:0] fmask(input logic [15:0] c0);
        return 16'((32'd2 << c0[3:0]) - 1);
    endfunction

    function automatic logic [7:0] ident(input int i);
        logic [7:0] t [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    function automatic logic [3:0] m_raw();
        return {(txq.size() <= 4), (rxq.size() >= 4), 2'b00};
    endfunction

    always @(posedge clk) begin : model
        int ts, rs;
        logic [15:0] fm;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_ctrl0 = '0; m_mask = '0; m_err = 0;
        end else begin
            ts = txq.size(); rs = rxq.size();
            fm = fmask(m_ctrl0);
            m_err = 0;
            if (sel) begin
                if (addr[1:0] != 2'b00 || (addr > 12'h020 && addr < 12'hFE0)) m_err = 1;
                else if (wr) begin
                    if (addr == 12'h000) m_ctrl0 = wdata;
                    if (addr == 12'h014) m_mask = wdata[3:0];
                    if (addr == 12'h008 && ts < 8) txq.push_back(wdata & fm);
                end else if (addr == 12'h008 && rs > 0) void'(rxq.pop_front());
            end
            if (tx_pop && ts > 0) void'(txq.pop_front());
            if (rx_push && rs < 8) rxq.push_back(rx_data & fm);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 tx_valid", tx_valid, txq.size() > 0);
            if (txq.size() > 0) chk("R4 tx_data", tx_data, txq[0]);
            chk("R7 rx_ready", rx_ready, rxq.size() < 8);
            chk("R9 irq_raw", irq_raw, m_raw());
            chk("R10 irq_masked", irq_masked, m_raw() & m_mask);
            chk("R10 irq", irq, (m_raw() & m_mask) != 0);
            chk("R11 bus_err", bus_err, m_err);
        end
    end

    task automatic step(input bit s, input bit w, input logic [11:0] a, input logic [15:0] d,
                        input bit tp, input bit rp, input logic [15:0] rd, output logic [15:0] q);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; tx_pop = tp; rx_push = rp; rx_data = rd;
        #1 q = rdata;
        @(posedge clk);
        #1 sel = 0; wr = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [15:0] d);
        logic [15:0] q;
        step(1, 1, a, d, 0, 0, 0, q);
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] q;
        step(1, 0, a, 0, 0, 0, 0, q);
        chk(tag, q, exp);
    endtask

    task automatic rdata_chk(input string tag);
        logic [15:0] e;
        e = (rxq.size() > 0) ? rxq[0] : 16'h0;
        rchk(tag, 12'h008, e);
    endtask

    task automatic txpop();
        logic [15:0] q;
        step(0, 0, 0, 0, 1, 0, 0, q);
    endtask

    task automatic rxput(input logic [15:0] d);
        logic [15:0] q;
        step(0, 0, 0, 0, 0, 1, d, q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] q;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rchk("R1 status", 12'h00C, 16'h0003);
        rchk("R1 raw", 12'h018, 16'h0008);
        rchk("R1 mask", 12'h014, 16'h0000);
        chk("R1 irq", irq, 0);

        // R2 register fields
        wreg(12'h000, 16'h0007); rchk("R2 ctrl0", 12'h000, 16'h0007);
        wreg(12'h004, 16'h00F2); rchk("R2 ctrl1", 12'h004, 16'h0002);
        chk("R2 ctrl1 port", ctrl1, 4'h2);
        wreg(12'h010, 16'h01AB); rchk("R2 prescale", 12'h010, 16'h00AB);
        chk("R2 prescale port", prescale, 8'hAB);
        wreg(12'h020, 16'h0005); rchk("R2 dma", 12'h020, 16'h0000);
        wreg(12'h014, 16'h00FF); rchk("R2 mask", 12'h014, 16'h000F);
        rchk("R10 masked word", 12'h01C, 16'h0008);
        chk("R10 irq on", irq, 1);
        wreg(12'h014, 16'h0000);

        // R3 identification bytes
        for (int i = 0; i < 8; i++) rchk("R3 ident", 12'hFE0 + 12'(i * 4), {8'h00, ident(i)});

        // R4 masking to 8 bits, ordering
        wreg(12'h008, 16'h01A5);
        chk("R4 masked tx", tx_data, 16'h00A5);
        rchk("R8 busy", 12'h00C, 16'h0012);
        txpop();
        chk("R4 popped", tx_valid, 0);

        // R5 full transmit FIFO, R9 tx threshold
        wreg(12'h000, 16'h000F);
        for (int i = 0; i < 8; i++) begin
            wreg(12'h008, 16'h1100 + 16'(i));
            if (i == 3) rchk("R9 tx at 4", 12'h018, 16'h0008);
            if (i == 4) rchk("R9 tx at 5", 12'h018, 16'h0000);
        end
        rchk("R8 tx full", 12'h00C, 16'h0010);
        wreg(12'h008, 16'h9999);
        for (int i = 0; i < 8; i++) begin
            chk("R5 order after drop", tx_data, 16'h1100 + 16'(i));
            txpop();
        end
        chk("R5 dropped word absent", tx_valid, 0);

        // R12 tx push and pop together
        wreg(12'h008, 16'h0AAA);
        step(1, 1, 12'h008, 16'h0BBB, 1, 0, 0, q);
        chk("R12 tx head", tx_data, 16'h0BBB);
        rchk("R12 tx level", 12'h00C, 16'h0012);
        txpop();

        // R7 receive fill, R9 rx threshold, R10 mask
        wreg(12'h014, 16'h0004);
        for (int i = 0; i < 9; i++) begin
            rxput(16'h2200 + 16'(i));
            if (i == 2) chk("R9 rx at 3", irq_raw[2], 0);
            if (i == 3) chk("R10 rx irq", irq, 1);
        end
        chk("R7 rx full", rx_ready, 0);
        rchk("R8 rx full", 12'h00C, 16'h000F);
        for (int i = 0; i < 8; i++) rdata_chk("R6 rx order");
        rchk("R6 empty read", 12'h008, 16'h0000);
        rchk("R6 empty state", 12'h00C, 16'h0003);
        wreg(12'h014, 16'h0000);

        // R7 rx masking, R12 rx push with read
        wreg(12'h000, 16'h0003);
        rxput(16'hABCD);
        step(1, 0, 12'h008, 0, 0, 1, 16'h1234, q);
        chk("R7 rx masked", q, 16'h000D);
        rdata_chk("R12 rx level");
        chk("R12 rx value", rxq.size(), 0);

        // R11 undefined offsets
        rchk("R11 read undefined", 12'h024, 16'h0000);
        chk("R11 err pulse", bus_err, 1);
        rchk("R11 read ctrl0", 12'h000, 16'h0003);
        chk("R11 err clears", bus_err, 0);
        wreg(12'h104, 16'hFFFF);
        wreg(12'h001, 16'h00FF);
        chk("R11 unaligned err", bus_err, 1);
        rchk("R11 no write", 12'h000, 16'h0003);
        rchk("R11 unaligned read", 12'h00A, 16'h0000);

        repeat (2) @(posedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule